// File: doc/BRIEF.md
# Parallel-Load Serial Shift Register with Gated Clock

This block is an eight-stage shift register that accepts a parallel word and streams it out one bit at a time. Data moves from the first stage (A) toward the last stage (H). A serial input fills stage A on each shift. The last stage is driven out both as a true bit and as its complement. An active-low load control copies the parallel word into the stages. The load is level-sensitive, and while it is active it overrides every other input.

Shifting is driven by an external clock pin and an inhibit pin that are combined by a logical OR. A shift happens on each rising edge of that combined signal while the load control is inactive. Holding either pin high therefore stops shifting, and holding one of them low lets the other act as the clock. The inhibit is meant to rise only while the clock pin is high. A rise of the inhibit while the clock is low makes a false edge, and the block flags it.

All external pins are sampled in one fast system clock domain. Each pin passes through a two-flop synchronizer, and edges are found by comparing the current and previous synchronized values. A change on a pin reaches the stages on the third system clock edge after it. A synchronous active-high reset clears all stages.

Top module: `piso_gated_shreg`

## Requirements
- R1: A synchronous reset (`rst_i` high at a system clock edge) clears every stage to 0, so `q_o` is 0 and `q_n_o` is 1.
- R2: While the synchronized `load_n_i` is low, every stage takes its bit of `par_i` (bit 0 is stage A, bit 7 is stage H). This happens whatever the levels of `gclk_pin_i`, `ginh_pin_i` and `ser_i`, and no shift takes place.
- R3: While the synchronized `load_n_i` is high, a rising edge of (`gclk_pin_i` OR `ginh_pin_i`) shifts once. Stage A takes `ser_i`, each other stage takes the stage before it, and `q_o` shows stage H.
- R4: While `ginh_pin_i` is held high, toggling `gclk_pin_i` leaves the stages unchanged.
- R5: While `gclk_pin_i` is held high, toggling `ginh_pin_i` leaves the stages unchanged. While `gclk_pin_i` is held low, a rise of `ginh_pin_i` shifts once.
- R6: With the load inactive and no rising edge of the combined clock, the stages hold their contents.
- R7: `q_n_o` is always the inverse of `q_o`.
- R8: `inh_err_o` pulses high for exactly one system cycle when the synchronized inhibit rises while the synchronized clock pin is low. A rise of the inhibit while the clock pin is high produces no pulse.
- R9: When a combined-clock rising edge and an active load fall in the same system cycle, the load wins and the stages equal `par_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| gclk_pin_i | input | 1 | External shift clock pin (asynchronous) |
| ginh_pin_i | input | 1 | External clock-inhibit pin (asynchronous) |
| load_n_i | input | 1 | Active-low parallel load |
| ser_i | input | 1 | Serial data into stage A |
| par_i | input | 8 | Parallel word, bit 0 to stage A, bit 7 to stage H |
| q_o | output | 1 | Stage H |
| q_n_o | output | 1 | Complement of stage H |
| inh_err_o | output | 1 | One-cycle pulse on an inhibit rise while the clock pin is low |

## Verification
The bench goes after the points where the gated clock is easy to get wrong. It toggles the clock pin under a high inhibit and the inhibit under a high clock pin. A design that gated with AND, or that took edges from either pin alone, would shift in those cases. The bench raises the clock pin in the same cycle as a load. A design that let the shift win would show a word displaced by one stage when it is read out. The bench also raises the inhibit while the clock pin is low and expects both one shift and one error pulse. A wrong direction of shift, or a serial bit entering at the wrong end, shows up as a mismatch at some step of each eight-step readout.

// File: rtl/piso_pkg.sv
package piso_pkg;
  // One shift step: stage 0 takes the serial bit, others move up by one.
  function automatic logic [7:0] shift_step(input logic [7:0] cur, input logic sin);
    return {cur[6:0], sin};
  endfunction

  // Combined shift clock of the two external lines.
  function automatic logic gate_clk(input logic c, input logic inh);
    return c | inh;
  endfunction
endpackage

// File: rtl/piso_sync.sv
module piso_sync #(
  parameter int W      = 1,
  parameter int DEPTH  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_flop
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= RST_VAL;
      else     chain[i] <= (i == 0) ? d : chain[(i == 0) ? 0 : i-1];
    end
  end

  assign q = chain[DEPTH-1];
endmodule

// File: rtl/piso_edge.sv
module piso_edge (
  input  logic clk,
  input  logic rst,
  input  logic clk_s,
  input  logic inh_s,
  output logic rise,
  output logic inh_err
);
  import piso_pkg::*;

  logic clk_q, inh_q;
  logic gclk_now, gclk_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_q <= 1'b0;
      inh_q <= 1'b0;
    end else begin
      clk_q <= clk_s;
      inh_q <= inh_s;
    end
  end

  assign gclk_now  = gate_clk(clk_s, inh_s);
  assign gclk_prev = gate_clk(clk_q, inh_q);
  assign rise      = gclk_now & ~gclk_prev;
  assign inh_err   = inh_s & ~inh_q & ~clk_s;
endmodule

// File: rtl/piso_stages.sv
module piso_stages #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic         sin,
  input  logic [N-1:0] par,
  output logic [N-1:0] stages
);
  import piso_pkg::*;

  always_ff @(posedge clk) begin
    if (rst)        stages <= '0;
    else if (load)  stages <= par;
    else if (shift) stages <= shift_step(stages, sin);
  end
endmodule

// File: rtl/piso_gated_shreg.sv
module piso_gated_shreg #(
  parameter int STAGES    = 8,
  parameter int SYNC_LVLS = 2
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              gclk_pin_i,
  input  logic              ginh_pin_i,
  input  logic              load_n_i,
  input  logic              ser_i,
  input  logic [STAGES-1:0] par_i,
  output logic              q_o,
  output logic              q_n_o,
  output logic              inh_err_o
);
  localparam int CTRL_W = 3;

  logic [CTRL_W-1:0] ctrl_s;
  logic              clk_s, inh_s, load_n_s;
  logic              ser_s;
  logic [STAGES-1:0] par_s;
  logic              load_act, rise, shift_fire;
  logic [STAGES-1:0] stage_q;

  // Control lines; load_n resets to inactive (high).
  piso_sync #(.W(CTRL_W), .DEPTH(SYNC_LVLS), .RST_VAL(3'b100)) u_sync_ctrl (
    .clk(clk_i), .rst(rst_i),
    .d({load_n_i, ginh_pin_i, gclk_pin_i}), .q(ctrl_s));

  piso_sync #(.W(STAGES + 1), .DEPTH(SYNC_LVLS), .RST_VAL('0)) u_sync_data (
    .clk(clk_i), .rst(rst_i),
    .d({ser_i, par_i}), .q({ser_s, par_s}));

  assign clk_s    = ctrl_s[0];
  assign inh_s    = ctrl_s[1];
  assign load_n_s = ctrl_s[2];
  assign load_act = ~load_n_s;

  piso_edge u_edge (
    .clk(clk_i), .rst(rst_i), .clk_s(clk_s), .inh_s(inh_s),
    .rise(rise), .inh_err(inh_err_o));

  // Load has priority; a shift only fires with the load inactive.
  assign shift_fire = rise & ~load_act;

  piso_stages #(.N(STAGES)) u_stages (
    .clk(clk_i), .rst(rst_i), .load(load_act), .shift(shift_fire),
    .sin(ser_s), .par(par_s), .stages(stage_q));

  assign q_o   = stage_q[STAGES-1];
  assign q_n_o = ~stage_q[STAGES-1];
endmodule

// File: rtl/piso_checker.sv
module piso_checker #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         load_act,
  input logic         rise,
  input logic         clk_s,
  input logic         inh_s,
  input logic         ser_s,
  input logic [N-1:0] par_s,
  input logic [N-1:0] stage_q,
  input logic         q,
  input logic         qn,
  input logic         err
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (stage_q == '0));

  assert_load_copy_R2: assert property (@(posedge clk) disable iff (rst)
    load_act |=> (stage_q == $past(par_s)));

  assert_shift_move_R3: assert property (@(posedge clk) disable iff (rst)
    (rise && !load_act) |=> (stage_q == {$past(stage_q[N-2:0]), $past(ser_s)}));

  assert_inh_blocks_R4: assert property (@(posedge clk) disable iff (rst)
    (inh_s && $past(inh_s) && !load_act) |=> $stable(stage_q));

  assert_clk_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    (clk_s && $past(clk_s) && !load_act) |=> $stable(stage_q));

  assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (!rise && !load_act) |=> $stable(stage_q));

  assert_complement_R7: assert property (@(posedge clk) disable iff (rst)
    qn == !q);

  assert_err_cause_R8: assert property (@(posedge clk) disable iff (rst)
    err |-> (inh_s && !clk_s && !$past(inh_s)));

  assert_err_single_R8: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);
endmodule

bind piso_gated_shreg piso_checker #(.N(STAGES)) u_chk (
  .clk(clk_i), .rst(rst_i), .load_act(load_act), .rise(rise),
  .clk_s(clk_s), .inh_s(inh_s), .ser_s(ser_s), .par_s(par_s),
  .stage_q(stage_q), .q(q_o), .qn(q_n_o), .err(inh_err_o));

// File: tb/piso_gated_shreg_bench.sv
module piso_gated_shreg_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       cpin, ipin, load_n, ser;
  logic [7:0] par;
  logic       q, qn, err;

  int tests = 0;
  int fails = 0;
  int err_cnt = 0;
  bit done = 0;
  logic [7:0] m;   // bench model, bit 0 = stage A

  piso_gated_shreg u_piso_gated_shreg (
    .clk_i(clk), .rst_i(rst), .gclk_pin_i(cpin), .ginh_pin_i(ipin),
    .load_n_i(load_n), .ser_i(ser), .par_i(par),
    .q_o(q), .q_n_o(qn), .inh_err_o(err));

  always #4 clk = ~clk;

  always @(negedge clk) if (!rst && err) err_cnt++;

  task automatic settle();
    repeat (5) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag);
    chk(q === m[7], tag, int'(q), int'(m[7]));
    chk(qn === ~m[7], {tag, " R7 complement"}, int'(qn), int'(~m[7]));
  endtask

  task automatic do_load(input logic [7:0] w);
    par = w; load_n = 1'b0; settle();
    load_n = 1'b1; settle();
    m = w;
  endtask

  // Rise then fall of the clock pin, inhibit low.
  task automatic pulse_clk(input logic s, input string tag);
    ser = s; cpin = 1'b1; settle();
    m = {m[6:0], s};
    chk_out(tag);
    cpin = 1'b0; settle();
  endtask

  task automatic readout(input logic s, input string tag);
    for (int k = 0; k < 8; k++) pulse_clk(s, tag);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cpin = 0; ipin = 0; load_n = 1; ser = 0; par = 8'h00;
    repeat (4) @(negedge clk);
    rst = 1'b0; settle();
    m = 8'h00;
    chk_out("R1 reset output");
    chk(err_cnt == 0, "R8 no error after reset", err_cnt, 0);

    // R2: load A..H = 1,0,1,0,1,0,1,1 while clock, inhibit and serial move
    par = 8'hD5; load_n = 1'b0; settle();
    ser = 1; cpin = 1; settle(); ipin = 1; settle(); cpin = 0; settle();
    m = 8'hD5;
    chk_out("R2 load under clock activity");
    load_n = 1'b1; settle();
    chk_out("R2 after load release");

    // R4: inhibit high, clock pin toggled
    for (int k = 0; k < 3; k++) begin
      cpin = 1; settle(); cpin = 0; settle();
      chk_out("R4 inhibit holds");
    end
    chk(err_cnt == 0, "R8 inhibit rose with clock high", err_cnt, 0);
    ipin = 0; settle();

    // R3: eight shifts with serial low
    readout(1'b0, "R3 shift ser=0");
    chk(q === 1'b0, "R3 drained to zero", int'(q), 0);

    // R3: second pattern, serial high
    do_load(8'h3C);
    readout(1'b1, "R3 shift ser=1");

    // R6: no edge, contents hold
    do_load(8'h96);
    repeat (20) @(negedge clk);
    chk_out("R6 hold without edge");

    // R5: clock pin high, inhibit toggles -> no shift, no error
    ser = 0; cpin = 1; settle(); m = {m[6:0], 1'b0};
    chk_out("R5 clock rise shift");
    for (int k = 0; k < 2; k++) begin
      ipin = 1; settle(); ipin = 0; settle();
      chk_out("R5 inhibit toggle under high clock");
    end
    chk(err_cnt == 0, "R8 no error with clock high", err_cnt, 0);
    cpin = 0; settle();

    // R5/R8: clock pin low, inhibit rise acts as clock and is flagged
    ser = 1; ipin = 1; settle(); m = {m[6:0], 1'b1};
    chk_out("R5 inhibit as clock");
    chk(err_cnt == 1, "R8 false edge flagged once", err_cnt, 1);
    ipin = 0; settle();
    readout(1'b0, "R5 contents after inhibit shift");

    // R9: clock rise together with load -> load wins
    par = 8'hA6; ser = 1;
    @(negedge clk); load_n = 0; cpin = 1; settle();
    load_n = 1; settle(); cpin = 0; settle();
    m = 8'hA6;
    chk_out("R9 load beats same-cycle edge");
    readout(1'b0, "R9 readout");

    // R1: reset mid-run with H set
    do_load(8'h80);
    chk_out("R1 preload");
    @(negedge clk); rst = 1; @(negedge clk); @(negedge clk); rst = 0;
    @(negedge clk);
    m = 8'h00;
    chk_out("R1 mid-run reset");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule